// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Counter

A four-bit synchronous counter that chains into multi-digit counters without any ripple gating between stages. A compile-time switch picks between a decimal digit (0 to 9) and a full binary nibble (0 to 15). A second switch picks a clear that acts on the clock edge or one that acts immediately. Each rising edge performs exactly one of four actions: clear, parallel load, increment or hold. The block selects the action in that priority order from an active-low clear, an active-low load and two active-high count enables.

The two enables are ANDed to allow counting. Only the trickle enable takes part in the terminal-count flag. That flag goes high when the trickle enable is high and the count sits at its top value. In a chain, the lowest stage has its trickle enable tied high. Each stage's flag drives the trickle enable of the stage above, and one shared parallel enable starts and stops the whole chain. In decimal mode the counter can be loaded with any of the six codes above nine. None of those codes raises the flag, and each one falls back into the legal cycle within two counting edges.

Top module: `casc_counter`

## Requirements
- R1: Every change of `q` takes place on a rising edge of `clk`, except the immediate clear in the asynchronous variant (`ASYNC_CLR`=1).
- R2: With `ASYNC_CLR`=1, `q` becomes 0 as soon as `clr_n` goes low, with no clock edge, and stays 0 while `clr_n` is low.
- R3: With `ASYNC_CLR`=0, a rising edge with `clr_n` low sets `q` to 0. Until that edge `q` keeps its value. The clear overrides `load_n`, `din` and both enables.
- R4: A rising edge with `clr_n` high and `load_n` low copies `din` into `q`, whatever the enables are. Any four-bit value is accepted in both modes.
- R5: A rising edge with `clr_n` and `load_n` high and both `en_p` and `en_t` high advances `q` by one step of the count sequence.
- R6: A rising edge with `clr_n` and `load_n` high and either enable low leaves `q` unchanged.
- R7: The top value is 9 (4'b1001) in decimal mode (`DECADE`=1) and 15 (4'b1111) in binary mode. A counting edge at the top value gives 0.
- R8: `tc` is high exactly when `en_t` is high and `q` equals the top value. It does not depend on `en_p` or `load_n`.
- R9: In decimal mode, a counting edge takes 10 to 11, 12 to 13 and 14 to 15, and takes 11, 13 and 15 to 0. `tc` stays low in states 10 to 15.
- R10: Three decimal stages, each stage's `tc` feeding the next stage's `en_t` and all stages sharing `en_p`, count 000 through 999 and back to 000. The top stage's `tc` is high only at 999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous according to `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel load |
| din | input | W | Parallel load data |
| en_p | input | 1 | Parallel count enable, ANDed with `en_t` |
| en_t | input | 1 | Trickle count enable, also qualifies `tc` |
| q | output | W | Current count |
| tc | output | 1 | Terminal count, for chaining stages |

## Verification
On every cycle the assertions check the clear in its configured form, the load copy, holding when an enable is low, wrapping from the top value, the tie between `tc` and `en_t`, and the decimal recovery from the odd illegal codes. Only the bench can show some of the behaviour. It needs a clear that lands mid-cycle, seen before and after the edge in both variants. It needs the full recovery paths from each illegal code. It also needs the complete thousand-step roll of a three-digit chain compared with an integer reference, including holds and a load in the middle of the sequence.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } cnt_op_e;

  // Step of the count sequence: wraps at top, odd codes above top go to zero
  function automatic logic [31:0] step_of(input logic [31:0] cur,
                                          input logic [31:0] top,
                                          input bit          decade);
    logic [31:0] nxt;
    if (cur == top)                          nxt = '0;
    else if (decade && cur > top && cur[0])  nxt = '0;
    else                                     nxt = cur + 32'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  always_comb begin
    if (!clr_n)              op = OP_CLEAR;
    else if (!load_n)        op = OP_LOAD;
    else if (en_p && en_t)   op = OP_COUNT;
    else                     op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next_val.sv
module cnt_next_val
  import cnt_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  cnt_op_e        op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   nxt
);
  localparam logic [31:0] TOP = DECADE ? 32'd9 : ((32'd1 << W) - 32'd1);

  logic [31:0] stepped;

  always_comb begin
    stepped = step_of(32'(cur), TOP, DECADE);
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = stepped[W-1:0];
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_tc_decode.sv
module cnt_tc_decode #(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [W-1:0] cur,
  input  logic         en_t,
  output logic         tc
);
  localparam logic [W-1:0] TOP = DECADE ? W'(9) : {W{1'b1}};

  assign tc = en_t && (cur == TOP);
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int W         = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] cur
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cur <= '0;
        else        cur <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        cur <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int W         = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] q,
  output logic         tc
);
  cnt_op_e      op;
  logic [W-1:0] nxt;

  cnt_mode_sel u_sel (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  cnt_next_val #(.W(W), .DECADE(DECADE)) u_next (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (nxt)
  );

  cnt_state_reg #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .cur   (q)
  );

  cnt_tc_decode #(.W(W), .DECADE(DECADE)) u_tc (
    .cur  (q),
    .en_t (en_t),
    .tc   (tc)
  );
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int W         = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic [W-1:0] din,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] q,
  input logic         tc
);
  localparam logic [W-1:0] TOP = DECADE ? W'(9) : {W{1'b1}};

  logic armed;
  always_ff @(posedge clk) begin
    if (!clr_n) armed <= 1'b1;
  end

  generate
    if (ASYNC_CLR) begin : g_ac
      // R2
      clear_async_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |-> (q == '0));
    end else begin : g_sc
      // R3
      clear_sync_chk: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (q == '0));
    end
  endgenerate

  // R4
  load_copy_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    !load_n |=> (q == $past(din)));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  // R7
  top_wrap_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    (load_n && en_p && en_t && q == TOP) |=> (q == '0));

  // R8
  tc_trickle_chk: assert property (@(posedge clk) disable iff (!armed)
    tc |-> en_t);

  generate
    if (DECADE) begin : g_dec
      // R9
      illegal_no_tc_chk: assert property (@(posedge clk) disable iff (!armed)
        (q > TOP) |-> !tc);
      // R9
      odd_recover_chk: assert property (@(posedge clk) disable iff (!armed || !clr_n)
        (load_n && en_p && en_t && q > TOP && q[0]) |=> (q == '0));
    end
  endgenerate
endmodule

bind casc_counter casc_counter_chk #(.W(W), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .din    (din),
  .en_p   (en_p),
  .en_t   (en_t),
  .q      (q),
  .tc     (tc)
);

// File: tb/tb_casc_counter.sv
`timescale 1ns/1ps
module tb_casc_counter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // shared stimulus for the two single-stage units
  logic       clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q_dec, q_bin;
  logic       tc_dec, tc_bin;

  // decimal digit, clock-edge clear
  casc_counter #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q_dec), .tc(tc_dec));

  // binary nibble, immediate clear
  casc_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) dut_bin (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q_bin), .tc(tc_bin));

  // three-digit chain
  logic       ch_clr_n = 1'b1, ch_load_n = 1'b1, ch_ep = 1'b0;
  logic [3:0] ch_din [3];
  logic [3:0] ch_q   [3];
  logic       ch_tc  [3];
  logic       ch_et  [3];

  assign ch_et[0] = 1'b1;
  assign ch_et[1] = ch_tc[0];
  assign ch_et[2] = ch_tc[1];

  for (genvar s = 0; s < 3; s++) begin : g_stage
    casc_counter #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u_st (
      .clk(clk), .clr_n(ch_clr_n), .load_n(ch_load_n), .din(ch_din[s]),
      .en_p(ch_ep), .en_t(ch_et[s]), .q(ch_q[s]), .tc(ch_tc[s]));
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int chain_val();
    return int'(ch_q[2]) * 100 + int'(ch_q[1]) * 10 + int'(ch_q[0]);
  endfunction

  // {load_n, din, en_p, en_t, exp_dec, exp_bin, exp_tc_dec, exp_tc_bin}
  localparam int NV = 21;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'd7,  1'b0, 1'b0, 4'd7,  4'd7,  1'b0, 1'b0}, // R4 load, enables low
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd8,  4'd8,  1'b0, 1'b0}, // R5
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd9,  4'd9,  1'b1, 1'b0}, // R8 dec at top
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd10, 1'b0, 1'b0}, // R7 dec wrap
    {1'b1, 4'd0,  1'b0, 1'b1, 4'd0,  4'd10, 1'b0, 1'b0}, // R6 en_p low
    {1'b0, 4'd9,  1'b0, 1'b0, 4'd9,  4'd9,  1'b0, 1'b0}, // R8 en_t low no tc
    {1'b1, 4'd0,  1'b0, 1'b1, 4'd9,  4'd9,  1'b1, 1'b0}, // R8 tc with en_p low
    {1'b1, 4'd0,  1'b1, 1'b0, 4'd9,  4'd9,  1'b0, 1'b0}, // R6 en_t low
    {1'b0, 4'd14, 1'b1, 1'b1, 4'd14, 4'd14, 1'b0, 1'b0}, // R4 load over count
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd15, 4'd15, 1'b0, 1'b1}, // R9 14->15
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 1'b0}, // R9 15->0, R7 bin
    {1'b0, 4'd10, 1'b1, 1'b1, 4'd10, 4'd10, 1'b0, 1'b0}, // R4
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd11, 4'd11, 1'b0, 1'b0}, // R9 10->11
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd12, 1'b0, 1'b0}, // R9 11->0
    {1'b0, 4'd12, 1'b1, 1'b1, 4'd12, 4'd12, 1'b0, 1'b0}, // R4
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd13, 4'd13, 1'b0, 1'b0}, // R9 12->13
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd14, 1'b0, 1'b0}, // R9 13->0
    {1'b0, 4'd15, 1'b1, 1'b0, 4'd15, 4'd15, 1'b0, 1'b0}, // R8 en_t low
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 1'b0}, // R9 / R7
    {1'b0, 4'd11, 1'b1, 1'b1, 4'd11, 4'd11, 1'b0, 1'b0}, // R4
    {1'b1, 4'd0,  1'b1, 1'b1, 4'd0,  4'd12, 1'b0, 1'b0}  // R9 11->0
  };

  initial begin : watchdog
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    ch_din[0] = 4'd0; ch_din[1] = 4'd0; ch_din[2] = 4'd0;
    #2;
    clr_n    = 1'b0;
    ch_clr_n = 1'b0;
    #1;
    chk("R2 immediate clear of binary unit", int'(q_bin), 0);
    repeat (3) @(posedge clk);
    #2;
    chk("R3 reset state dec", int'(q_dec), 0);
    chk("R2 reset state bin", int'(q_bin), 0);
    chk("R8 reset tc dec", int'(tc_dec), 0);
    chk("R10 reset chain", chain_val(), 0);
    @(negedge clk);
    clr_n    = 1'b1;
    ch_clr_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {load_n, din, en_p, en_t} = VEC[i][16:10];
      @(posedge clk);
      #2;
      chk($sformatf("R4-R9 vec%0d dec q", i), int'(q_dec), int'(VEC[i][9:6]));
      chk($sformatf("R4-R9 vec%0d bin q", i), int'(q_bin), int'(VEC[i][5:2]));
      chk($sformatf("R8 vec%0d dec tc",   i), int'(tc_dec), int'(VEC[i][1]));
      chk($sformatf("R8 vec%0d bin tc",   i), int'(tc_bin), int'(VEC[i][0]));
      @(negedge clk);
    end

    // clear landing mid-cycle while load and count are also requested
    load_n = 1'b0; din = 4'd6; en_p = 1'b0; en_t = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R4 preload dec", int'(q_dec), 6);
    clr_n = 1'b0; load_n = 1'b0; din = 4'd5; en_p = 1'b1; en_t = 1'b1;
    #1;
    chk("R2 bin clears without edge", int'(q_bin), 0);
    chk("R1 R3 dec waits for edge", int'(q_dec), 6);
    @(posedge clk);
    #2;
    chk("R3 clear beats load", int'(q_dec), 0);
    chk("R2 bin held clear", int'(q_bin), 0);
    @(negedge clk);
    clr_n = 1'b1; load_n = 1'b1; en_p = 1'b0;
    @(posedge clk);
    #2;
    chk("R1 R6 idle after clear", int'(q_dec), 0);

    // chain: full roll of 1000 counts
    @(negedge clk);
    ch_ep = 1'b1;
    for (int n = 1; n <= 1000; n++) begin
      @(posedge clk);
      #2;
      chk($sformatf("R10 chain step %0d", n), chain_val(), n % 1000);
      chk($sformatf("R10 chain tc step %0d", n), int'(ch_tc[2]),
          ((n % 1000) == 999) ? 1 : 0);
    end

    // chain hold
    @(negedge clk);
    ch_ep = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R6 chain hold", chain_val(), 0);

    // chain load 998 then count through the top
    @(negedge clk);
    ch_din[0] = 4'd8; ch_din[1] = 4'd9; ch_din[2] = 4'd9;
    ch_load_n = 1'b0;
    @(posedge clk);
    #2;
    chk("R4 chain load", chain_val(), 998);
    @(negedge clk);
    ch_load_n = 1'b1; ch_ep = 1'b1;
    @(posedge clk);
    #2;
    chk("R10 chain to 999", chain_val(), 999);
    @(negedge clk);
    ch_ep = 1'b0;
    #1;
    chk("R8 chain tc with en_p low", int'(ch_tc[2]), 1);
    @(posedge clk);
    #2;
    chk("R6 chain hold at 999", chain_val(), 999);
    @(negedge clk);
    ch_ep = 1'b1;
    @(posedge clk);
    #2;
    chk("R10 chain 999 to 000", chain_val(), 0);
    chk("R10 chain tc after roll", int'(ch_tc[2]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule